// File: doc/BRIEF.md
# Clause-22 Management Command Register

This block gives software one 32-bit command/status word through which it drives a clause-22 MDIO management master. A single write to the word supplies the target PHY address, the register number, a read/write flag and, for writes, a 16-bit value. The block then sends a complete management frame on MDC/MDIO while a busy flag is raised. For a read, it releases MDIO for the turnaround and data bits and shifts in the PHY's answer on each rising MDC edge. At the end of the frame it places the 16 bits in the data field of the same word and raises a read-valid flag.

A second, 5-bit register holds the PHY address of the port itself. It sits beside the command word and is selected with a one-bit register select. MDC is the system clock divided by a parameter, and it rests low whenever no frame is in flight.

Top module: `mdio_cmd_port`

## Requirements
- R1: After reset the command word reads 0 (busy and read-valid clear), the local address register reads 0, MDC is low and MDIO is not driven.
- R2: Command word fields are: bits 15:0 data, bits 20:16 PHY address, bits 25:21 register number, bit 26 operation (1 = read, 0 = write), bit 27 read-valid, bit 28 busy. Bits 27, 28 and 31:29 are read-only, and bits 31:29 read 0.
- R3: Each frame is sent MSB first and opens with 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register number. MDIO is stable while MDC is high.
- R4: A write frame continues with turnaround bits 10 and the 16 data bits. MDIO is driven for all 64 bits.
- R5: In a read frame MDIO is released for the two turnaround bits and the 16 data bits. The PHY's bits are taken on the rising MDC edge, MSB first, and appear in bits 15:0 of the command word when the frame ends.
- R6: Busy reads 1 from the cycle after an accepted command until the frame ends. A frame is 64 MDC pulses, and each MDC high and low phase lasts HALF_DIV clock cycles, which is 256 busy cycles at the default of 2.
- R7: Read-valid is set when a read frame ends and stays set until the next accepted command write, which clears it. It stays clear after a write frame.
- R8: A command write while busy is set is ignored: the frame in flight and the fields read back are unchanged.
- R9: A write to the local address register (select = 1) stores only wdata[4:0]. Bits 31:5 of that register read 0.
- R10: MDC is low and MDIO is not driven whenever busy is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the command word, 1 the local address register |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for management data |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or shift register shows up within one frame as a misplaced field in the captured serial word, or as a busy window other than 256 cycles. A wrong divider state shows up at once as an MDC phase length other than HALF_DIV. A bad read path shows up at the end of the read frame, either as a wrong data field or as a read-valid flag that fails to rise or is not cleared by the next command. A missed busy guard shows up in the same frame: a second command corrupts the bits still to be sent and the fields that read back.

// File: rtl/mdio_cmd_port.sv
module mdio_cmd_port #(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int FRAME    = 64;
  localparam int IDX_W    = $clog2(FRAME);
  localparam int TA_IDX   = 46;
  localparam int DATA_IDX = 48;

  logic             busy_q, valid_q, half_q;
  logic             cmd_rd;
  logic [4:0]       cmd_phy, cmd_reg, local_phy;
  logic [15:0]      cmd_data, rx_q;
  logic [IDX_W-1:0] idx_q;
  logic [DIV_W-1:0] div_q;
  logic [FRAME-1:0] sh_q;

  wire cmd_wr   = wr_en && !reg_sel;
  wire accept   = cmd_wr && !busy_q;
  wire tick     = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
  wire rise     = tick && !half_q;
  wire fall     = tick && half_q;
  wire last_bit = (idx_q == IDX_W'(FRAME - 1));

  assign mdc     = half_q;
  assign mdio_o  = sh_q[FRAME-1];
  assign mdio_oe = busy_q && !(cmd_rd && idx_q >= IDX_W'(TA_IDX));
  assign rdata   = reg_sel ? {27'd0, local_phy}
                           : {3'd0, busy_q, valid_q, cmd_rd, cmd_reg, cmd_phy, cmd_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) local_phy <= '0;
    else if (wr_en && reg_sel) local_phy <= wdata[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      half_q   <= 1'b0;
      cmd_rd   <= 1'b0;
      cmd_phy  <= '0;
      cmd_reg  <= '0;
      cmd_data <= '0;
      rx_q     <= '0;
      idx_q    <= '0;
      div_q    <= '0;
      sh_q     <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      valid_q  <= 1'b0;
      half_q   <= 1'b0;
      idx_q    <= '0;
      div_q    <= '0;
      cmd_rd   <= wdata[26];
      cmd_reg  <= wdata[25:21];
      cmd_phy  <= wdata[20:16];
      cmd_data <= wdata[15:0];
      sh_q     <= {32'hFFFF_FFFF, 2'b01, wdata[26] ? 2'b10 : 2'b01,
                   wdata[20:16], wdata[25:21], 2'b10, wdata[15:0]};
    end else if (busy_q) begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (rise) begin
        half_q <= 1'b1;
        if (cmd_rd && idx_q >= IDX_W'(DATA_IDX)) rx_q <= {rx_q[14:0], mdio_i};
      end
      if (fall) begin
        half_q <= 1'b0;
        if (last_bit) begin
          busy_q <= 1'b0;
          if (cmd_rd) begin
            valid_q  <= 1'b1;
            cmd_data <= rx_q;
          end
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/mdio_cmd_port_chk.sv
module mdio_cmd_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_sel,
  input logic        wr_en,
  input logic [31:0] rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        valid,
  input logic        cmd_rd,
  input logic [4:0]  cmd_phy,
  input logic [4:0]  cmd_reg
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !reg_sel) |=> ($stable(cmd_phy) && $stable(cmd_reg) && $stable(cmd_rd))); // R8

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && !reg_sel) |=> (busy && !valid)); // R7

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($fell(busy) && cmd_rd)); // R7

  AST_OE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mdio_oe)) |-> cmd_rd); // R5

  AST_MDIO_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o)); // R3

  AST_LOCAL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (rdata[31:5] == 27'd0)); // R9

endmodule

bind mdio_cmd_port mdio_cmd_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rdata(rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy_q), .valid(valid_q),
  .cmd_rd(cmd_rd), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg)
);

// File: tb/test_mdio_cmd_port.sv
module test_mdio_cmd_port;
  localparam int HALF_DIV = 2;
  localparam int NVEC = 6;
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  5'd1,  16'h1234},
    {1'b1, 5'd31, 5'd31, 16'hA5C3},
    {1'b0, 5'd31, 5'd0,  16'h0000},
    {1'b1, 5'd1,  5'd0,  16'hFFFF},
    {1'b0, 5'd0,  5'd31, 16'hFFFF},
    {1'b1, 5'd10, 5'd17, 16'h0001}
  };

  logic clk = 0, rst_n = 0, reg_sel = 0, wr_en = 0, mdio_i = 0;
  logic [31:0] wdata = 0, rdata;
  logic mdc, mdio_o, mdio_oe;

  int n_chk = 0, n_bad = 0;
  int bitn = 0;
  logic [63:0] cap, oecap;
  logic [15:0] resp = 0;
  int busy_cyc, mdc_hi;

  always #2 clk = ~clk;

  mdio_cmd_port #(.HALF_DIV(HALF_DIV)) i_mdio_cmd_port (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial forever begin
    @(posedge mdc);
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe};
    if (bitn + 1 >= 48 && bitn + 1 <= 63) mdio_i = resp[15 - (bitn + 1 - 48)];
    bitn++;
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0; reg_sel = 0;
  endtask

  task automatic bus_read(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #0.5 d = rdata;
    reg_sel = 0;
  endtask

  task automatic wait_frame();
    busy_cyc = 0; mdc_hi = 0;
    while (rdata[28] === 1'b1 && busy_cyc < 2000) begin
      busy_cyc++;
      if (mdc) mdc_hi++;
      @(negedge clk);
    end
  endtask

  task automatic start_cmd(input logic [31:0] cmd, input logic [15:0] r);
    bitn = 0; cap = 0; oecap = 0; resp = r; mdio_i = 0;
    bus_write(0, cmd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    check("R1 mdc/oe in reset", {mdc, mdio_oe}, 0);
    rst_n = 1;
    bus_read(0, d); check("R1 cmd word reset", d, 0);
    bus_read(1, d); check("R1 local addr reset", d, 0);
    check("R10 idle mdc/oe", {mdc, mdio_oe}, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic rd;
      rd = VEC[i][26];
      start_cmd({5'd0, VEC[i]}, VEC[i][15:0]);
      check("R6 busy after accept", rdata[28], 1);
      wait_frame();
      check("R6 busy window", busy_cyc, 64 * 2 * HALF_DIV);
      check("R6 mdc high time", mdc_hi, 64 * HALF_DIV);
      check("R6 mdc pulses", bitn, 64);
      check("R10 idle after frame", {mdc, mdio_oe}, 0);
      exp = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, VEC[i][20:16], VEC[i][25:21],
             2'b10, VEC[i][15:0]};
      bus_read(0, d);
      if (rd) begin
        check("R3 read header", cap[63:18], exp[63:18]);
        check("R5 read release", oecap, {{46{1'b1}}, 18'd0});
        check("R5 read data", d[15:0], VEC[i][15:0]);
        check("R7 valid after read", d[27], 1);
      end else begin
        check("R4 write frame", cap, exp);
        check("R4 write drive", oecap, {64{1'b1}});
        check("R7 valid after write", d[27], 0);
      end
      check("R2 fields readback", {d[31:28], d[26:16]}, {4'd0, VEC[i][26:16]});
    end

    // R7: valid holds, then a new command clears it
    start_cmd({5'd0, 1'b1, 5'd3, 5'd4, 16'h0}, 16'h5A5A);
    wait_frame();
    repeat (20) @(negedge clk);
    bus_read(0, d); check("R7 valid persists", {d[27], d[15:0]}, {1'b1, 16'h5A5A});
    start_cmd({5'd0, 1'b0, 5'd3, 5'd4, 16'h0}, 16'h0);
    check("R7 valid cleared by command", rdata[27], 0);
    wait_frame();

    // R8: command during busy ignored
    start_cmd({5'd0, 1'b0, 5'd5, 5'd9, 16'hC0DE}, 16'h0);
    repeat (30) @(negedge clk);
    bus_write(0, {5'd0, 1'b1, 5'd22, 5'd13, 16'h1111});
    bus_read(0, d); check("R8 fields during busy", d[26:0], {1'b0, 5'd5, 5'd9, 16'hC0DE});
    wait_frame();
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd5, 2'b10, 16'hC0DE};
    check("R8 frame unchanged", cap, exp);
    check("R8 still driven", oecap, {64{1'b1}});

    // R9: local address register
    bus_write(1, 32'hFFFF_FFEA);
    bus_read(1, d); check("R9 local addr low bits", d, 32'h0000_000A);
    bus_read(0, d); check("R9 cmd word untouched", d[26:0], {1'b0, 5'd5, 5'd9, 16'hC0DE});
    check("R10 idle at end", {mdc, mdio_oe}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule